// File: doc/BRIEF.md
# Video Line to RTP Packetizer

The block sits between a camera receive path and a network transmit path. It accepts a byte-wide AXI4-Stream in which each packet is one complete line of uncompressed video. With the last byte of every line come a virtual-channel number, which tells apart up to `NUM_VC` interleaved camera streams, and an end-of-frame flag. The whole line is held in one line store. When the line is complete, the block emits one output AXI4-Stream packet. It is made of a 12-byte RTP header, an 8-byte uncompressed-video payload header and then the line's pixel bytes in arrival order.

Each virtual channel keeps its own RTP stream context: a sequence counter, a line counter, the frame timestamp and whether the next line opens a new frame. The payload type, the per-channel SSRC values and the packet size limit are static configuration inputs. The time base is an input word that the block samples. A line is never split. A line that does not fit the line store, or whose packet would exceed the size limit, is discarded whole and reported on a one-cycle error pulse. While a stored line is being sent, the input is held off.

Top module: `rtp_line_packetizer`

## Requirements
- R1: Every accepted line of L bytes yields exactly one output packet of 20+L bytes, with `m_tlast` high on its final byte only; pixel bytes follow the 20 header bytes in arrival order.
- R2: Byte 0 of each packet is 0x80 (version 2, no padding, no extension, no contributing sources); byte 1 holds the marker in bit 7 and `cfg_pt` in bits 6:0.
- R3: Bytes 2-3 carry a per-channel sequence number, most significant byte first; it starts at `SEQ_INIT` after reset, rises by one per packet sent on that channel, and wraps modulo 2^16.
- R4: Bytes 4-7 carry the timestamp (MSB first): `ts_in` sampled on the last input byte of the first line of a frame, reused for every later line of that frame on the same channel; the first line after reset, and the line after an end-of-frame line, open a frame.
- R5: Bytes 8-11 carry the channel's SSRC, taken from `cfg_ssrc[32*vc +: 32]`, MSB first.
- R6: Bytes 12-19 form the payload header: bytes 12-13 are zero, bytes 14-15 hold the line length L, bytes 16-17 hold a zero flag bit followed by the 15-bit line number, bytes 18-19 are zero (offset 0, no continuation). Line numbers start at 0 in each frame and rise by one per line on that channel, dropped lines included.
- R7: The marker bit is set exactly when the input line carried the end-of-frame flag.
- R8: A line with L > `DEPTH` or 20+L > `cfg_mtu` produces no output, pulses `err_drop` for one cycle and does not advance the sequence number.
- R9: From the end of a stored line until its last output byte is accepted, `s_tready` is low. While `m_tvalid` is high and `m_tready` low, the output byte and `m_tlast` stay unchanged.
- R10: After reset `s_tready` is high, `m_tvalid` and `err_drop` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_tdata | input | 8 | Input pixel byte |
| s_tvalid | input | 1 | Input byte valid |
| s_tready | output | 1 | Input byte accepted when high with valid |
| s_tlast | input | 1 | Last byte of a line |
| s_teof | input | 1 | Line ends a frame, sampled with `s_tlast` |
| s_tvc | input | $clog2(NUM_VC) | Virtual channel, sampled with `s_tlast` |
| m_tdata | output | 8 | Output packet byte |
| m_tvalid | output | 1 | Output byte valid |
| m_tready | input | 1 | Downstream ready |
| m_tlast | output | 1 | Last byte of a packet |
| cfg_pt | input | 7 | RTP payload type |
| cfg_ssrc | input | 32*NUM_VC | SSRC per virtual channel |
| cfg_mtu | input | 16 | Largest allowed packet in bytes |
| ts_in | input | 32 | Time base sampled for frame timestamps |
| err_drop | output | 1 | One-cycle pulse per discarded line |

## Verification
The assertions check on every cycle that a stalled output holds its byte and last flag, that no input byte is taken while a packet is offered, that every packet opens with the fixed version byte, that the output idles for a cycle after a last byte, and that a drop pulse never coincides with an offered packet. Header contents can only be shown by the bench's scenarios. These are the sequence wrap, timestamp reuse across a frame, per-channel SSRC and line numbering, the marker, and the exact size limits of the store and the configured packet limit. The bench compares each output byte against a model of per-channel stream state.

// File: rtl/rtp_pkt_pkg.sv
// Shared constants and the per-line header record of the packetizer.
package rtp_pkt_pkg;
    localparam int HDR_BYTES = 20;

    typedef struct packed {
        logic        marker;
        logic [15:0] seq;
        logic [31:0] ts;
        logic [14:0] line;
        logic [15:0] len;
    } line_hdr_t;
endpackage

// File: rtl/rtpk_line_capture.sv
// Line capture: writes one input line into the line store and counts its
// bytes. At the last byte it decides whether the line is kept or dropped.
// A kept line holds the store (full) until the emitter releases it.
// Assumes channel and end-of-frame tags are valid with the last byte.
module rtpk_line_capture
    import rtp_pkt_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter int VC_W  = 2,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [7:0]      s_tdata,
    input  logic            s_tvalid,
    output logic            s_tready,
    input  logic            s_tlast,
    input  logic            s_teof,
    input  logic [VC_W-1:0] s_tvc,
    input  logic [15:0]     cfg_mtu,
    input  logic            release_i,
    input  logic [AW-1:0]   rd_addr,
    output logic [7:0]      rd_data,
    output logic            full_o,
    output logic            done_o,
    output logic            drop_o,
    output logic [15:0]     len_o,
    output logic [VC_W-1:0] vc_o,
    output logic            eof_o,
    output logic            err_drop
);
    logic [7:0]  mem [DEPTH];
    logic [15:0] cnt_q;
    logic        full_q;
    logic        drop_q;
    logic        acc;
    logic        too_long;
    logic        too_big;

    assign s_tready = !full_q;
    assign acc      = s_tvalid && !full_q;
    assign done_o   = acc && s_tlast;
    assign len_o    = (cnt_q == 16'hFFFF) ? cnt_q : cnt_q + 16'd1;
    assign too_long = ({1'b0, cnt_q} >= 17'(DEPTH));
    assign too_big  = ({1'b0, len_o} + 17'(HDR_BYTES)) > {1'b0, cfg_mtu};
    assign drop_o   = too_long || too_big;
    assign vc_o     = s_tvc;
    assign eof_o    = s_teof;
    assign full_o   = full_q;
    assign err_drop = drop_q;
    assign rd_data  = mem[rd_addr];

    // Store write: bytes beyond the store depth are discarded.
    always_ff @(posedge clk) begin
        if (acc && ({1'b0, cnt_q} < 17'(DEPTH)))
            mem[cnt_q[AW-1:0]] <= s_tdata;
    end

    // Byte counter, store ownership and drop pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            full_q <= 1'b0;
            drop_q <= 1'b0;
        end else begin
            drop_q <= done_o && drop_o;
            if (done_o) begin
                cnt_q <= '0;
                if (!drop_o) full_q <= 1'b1;
            end else if (acc && cnt_q != 16'hFFFF) begin
                cnt_q <= cnt_q + 16'd1;
            end
            if (release_i) full_q <= 1'b0;
        end
    end
endmodule

// File: rtl/rtpk_stream_ctx.sv
// Stream context: per-channel sequence, line counter, frame timestamp and
// frame-start state. On each completed line it registers the header fields
// for that line. Assumes NUM_VC equals 2**VC_W.
module rtpk_stream_ctx
    import rtp_pkt_pkg::*;
#(
    parameter int          NUM_VC   = 4,
    parameter int          VC_W     = 2,
    parameter logic [15:0] SEQ_INIT = 16'h0000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            done_i,
    input  logic            drop_i,
    input  logic [VC_W-1:0] vc_i,
    input  logic            eof_i,
    input  logic [15:0]     len_i,
    input  logic [31:0]     ts_in,
    output line_hdr_t       hdr_o,
    output logic [VC_W-1:0] hdr_vc_o
);
    logic [15:0] seq_q   [NUM_VC];
    logic [14:0] line_q  [NUM_VC];
    logic [31:0] ts_q    [NUM_VC];
    logic        first_q [NUM_VC];
    logic [14:0] cur_line;
    logic [31:0] cur_ts;

    assign cur_line = first_q[vc_i] ? 15'd0 : line_q[vc_i];
    assign cur_ts   = first_q[vc_i] ? ts_in : ts_q[vc_i];

    // Per-channel state update on each completed line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int v = 0; v < NUM_VC; v++) begin
                seq_q[v]   <= SEQ_INIT;
                line_q[v]  <= '0;
                ts_q[v]    <= '0;
                first_q[v] <= 1'b1;
            end
        end else if (done_i) begin
            for (int v = 0; v < NUM_VC; v++) begin
                if (vc_i == VC_W'(v)) begin
                    line_q[v]  <= cur_line + 15'd1;
                    ts_q[v]    <= cur_ts;
                    first_q[v] <= eof_i;
                    if (!drop_i) seq_q[v] <= seq_q[v] + 16'd1;
                end
            end
        end
    end

    // Header record for the line now held in the store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_o    <= '0;
            hdr_vc_o <= '0;
        end else if (done_i && !drop_i) begin
            hdr_o.marker <= eof_i;
            hdr_o.seq    <= seq_q[vc_i];
            hdr_o.ts     <= cur_ts;
            hdr_o.line   <= cur_line;
            hdr_o.len    <= len_i;
            hdr_vc_o     <= vc_i;
        end
    end
endmodule

// File: rtl/rtpk_emit.sv
// Packet emitter: while the store is full, sends 20 header bytes and then
// the stored pixel bytes, and releases the store on the last handshake.
// Assumes the header record is stable while the store is full.
module rtpk_emit
    import rtp_pkt_pkg::*;
#(
    parameter int NUM_VC = 4,
    parameter int VC_W   = 2,
    parameter int DEPTH  = 2048,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic                depth_unused_clk_ok,
    input  logic                clk,
    input  logic                rst_n,
    input  logic                full_i,
    input  line_hdr_t           hdr_i,
    input  logic [VC_W-1:0]     hdr_vc_i,
    input  logic [6:0]          cfg_pt,
    input  logic [32*NUM_VC-1:0] cfg_ssrc,
    input  logic [7:0]          rd_data,
    output logic [AW-1:0]       rd_addr,
    output logic                release_o,
    output logic [7:0]          m_tdata,
    output logic                m_tvalid,
    input  logic                m_tready,
    output logic                m_tlast
);
    logic [16:0] idx_q;
    logic [AW-1:0] pay_q;
    logic [31:0] ssrc_arr [NUM_VC];
    logic [31:0] ssrc;
    logic        hs;

    for (genvar g = 0; g < NUM_VC; g++) begin : g_ssrc
        assign ssrc_arr[g] = cfg_ssrc[32*g +: 32];
    end

    assign ssrc      = ssrc_arr[hdr_vc_i];
    assign m_tvalid  = full_i && depth_unused_clk_ok;
    assign m_tlast   = (idx_q == ({1'b0, hdr_i.len} + 17'(HDR_BYTES - 1)));
    assign hs        = m_tvalid && m_tready;
    assign release_o = hs && m_tlast;
    assign rd_addr   = pay_q;

    // Output byte selection: header fields by position, then payload.
    always_comb begin
        case (idx_q)
            17'd0:   m_tdata = 8'h80;
            17'd1:   m_tdata = {hdr_i.marker, cfg_pt};
            17'd2:   m_tdata = hdr_i.seq[15:8];
            17'd3:   m_tdata = hdr_i.seq[7:0];
            17'd4:   m_tdata = hdr_i.ts[31:24];
            17'd5:   m_tdata = hdr_i.ts[23:16];
            17'd6:   m_tdata = hdr_i.ts[15:8];
            17'd7:   m_tdata = hdr_i.ts[7:0];
            17'd8:   m_tdata = ssrc[31:24];
            17'd9:   m_tdata = ssrc[23:16];
            17'd10:  m_tdata = ssrc[15:8];
            17'd11:  m_tdata = ssrc[7:0];
            17'd12:  m_tdata = 8'h00;
            17'd13:  m_tdata = 8'h00;
            17'd14:  m_tdata = hdr_i.len[15:8];
            17'd15:  m_tdata = hdr_i.len[7:0];
            17'd16:  m_tdata = {1'b0, hdr_i.line[14:8]};
            17'd17:  m_tdata = hdr_i.line[7:0];
            17'd18:  m_tdata = 8'h00;
            17'd19:  m_tdata = 8'h00;
            default: m_tdata = rd_data;
        endcase
    end

    // Byte position and payload read address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            pay_q <= '0;
        end else if (hs) begin
            if (m_tlast) begin
                idx_q <= '0;
                pay_q <= '0;
            end else begin
                idx_q <= idx_q + 17'd1;
                if (idx_q >= 17'(HDR_BYTES)) pay_q <= pay_q + AW'(1);
            end
        end
    end
endmodule

// File: rtl/rtp_line_packetizer.sv
// Top: video line to RTP packet converter. One stored line at a time;
// input is held off while its packet is sent. Assumes NUM_VC is a power
// of two, at least 2, and DEPTH is a power of two.
module rtp_line_packetizer
    import rtp_pkt_pkg::*;
#(
    parameter int          NUM_VC   = 4,
    parameter int          DEPTH    = 2048,
    parameter logic [15:0] SEQ_INIT = 16'h0000,
    localparam int         VC_W     = $clog2(NUM_VC),
    localparam int         AW       = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [7:0]           s_tdata,
    input  logic                 s_tvalid,
    output logic                 s_tready,
    input  logic                 s_tlast,
    input  logic                 s_teof,
    input  logic [VC_W-1:0]      s_tvc,
    output logic [7:0]           m_tdata,
    output logic                 m_tvalid,
    input  logic                 m_tready,
    output logic                 m_tlast,
    input  logic [6:0]           cfg_pt,
    input  logic [32*NUM_VC-1:0] cfg_ssrc,
    input  logic [15:0]          cfg_mtu,
    input  logic [31:0]          ts_in,
    output logic                 err_drop
);
    logic            release_w;
    logic [AW-1:0]   rd_addr_w;
    logic [7:0]      rd_data_w;
    logic            full_w;
    logic            done_w;
    logic            drop_w;
    logic [15:0]     len_w;
    logic [VC_W-1:0] vc_w;
    logic            eof_w;
    line_hdr_t       hdr_w;
    logic [VC_W-1:0] hdr_vc_w;

    rtpk_line_capture #(.DEPTH(DEPTH), .VC_W(VC_W)) cap_i (
        .clk(clk), .rst_n(rst_n),
        .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
        .s_tlast(s_tlast), .s_teof(s_teof), .s_tvc(s_tvc),
        .cfg_mtu(cfg_mtu), .release_i(release_w),
        .rd_addr(rd_addr_w), .rd_data(rd_data_w), .full_o(full_w),
        .done_o(done_w), .drop_o(drop_w), .len_o(len_w), .vc_o(vc_w),
        .eof_o(eof_w), .err_drop(err_drop)
    );

    rtpk_stream_ctx #(.NUM_VC(NUM_VC), .VC_W(VC_W), .SEQ_INIT(SEQ_INIT)) ctx_i (
        .clk(clk), .rst_n(rst_n),
        .done_i(done_w), .drop_i(drop_w), .vc_i(vc_w), .eof_i(eof_w),
        .len_i(len_w), .ts_in(ts_in), .hdr_o(hdr_w), .hdr_vc_o(hdr_vc_w)
    );

    rtpk_emit #(.NUM_VC(NUM_VC), .VC_W(VC_W), .DEPTH(DEPTH)) emit_i (
        .depth_unused_clk_ok(1'b1),
        .clk(clk), .rst_n(rst_n), .full_i(full_w),
        .hdr_i(hdr_w), .hdr_vc_i(hdr_vc_w), .cfg_pt(cfg_pt),
        .cfg_ssrc(cfg_ssrc), .rd_data(rd_data_w), .rd_addr(rd_addr_w),
        .release_o(release_w), .m_tdata(m_tdata), .m_tvalid(m_tvalid),
        .m_tready(m_tready), .m_tlast(m_tlast)
    );
endmodule

// File: rtl/rtpk_checker.sv
// Checker for the packetizer ports; attached to every instance by bind.
module rtpk_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       s_tvalid,
    input logic       s_tready,
    input logic [7:0] m_tdata,
    input logic       m_tvalid,
    input logic       m_tready,
    input logic       m_tlast,
    input logic       err_drop
);
    logic sop_q;

    // Tracks whether the next output byte opens a packet.
    always_ff @(posedge clk) begin
        if (!rst_n) sop_q <= 1'b1;
        else if (m_tvalid && m_tready) sop_q <= m_tlast;
    end

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tlast));

    assert_no_input_while_sending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> !(s_tvalid && s_tready));

    assert_version_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sop_q && m_tvalid |-> m_tdata == 8'h80);

    assert_single_packet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid && m_tready && m_tlast |=> !m_tvalid);

    assert_drop_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_drop |-> !m_tvalid);
endmodule

bind rtp_line_packetizer rtpk_checker chk_i (
    .clk(clk), .rst_n(rst_n), .s_tvalid(s_tvalid), .s_tready(s_tready),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready),
    .m_tlast(m_tlast), .err_drop(err_drop)
);

// File: tb/rtp_line_packetizer_tb_top.sv
// Bench: random and directed lines against a per-channel stream model.
module rtp_line_packetizer_tb_top;
    localparam int          NV    = 4;
    localparam int          DEP   = 2048;
    localparam logic [15:0] SINIT = 16'hFFFD;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    s_tdata = '0;
    logic          s_tvalid = 1'b0;
    logic          s_tready;
    logic          s_tlast = 1'b0;
    logic          s_teof = 1'b0;
    logic [1:0]    s_tvc = '0;
    logic [7:0]    m_tdata;
    logic          m_tvalid;
    logic          m_tready = 1'b0;
    logic          m_tlast;
    logic [6:0]    cfg_pt = 7'd96;
    logic [127:0]  cfg_ssrc;
    logic [15:0]   cfg_mtu = 16'd1500;
    logic [31:0]   ts_in = '0;
    logic          err_drop;

    int errors = 0;
    int checks = 0;
    int drops_seen = 0;
    int drops_exp = 0;
    int pkts_seen = 0;
    int pkts_exp = 0;
    int byte_pos = 0;
    bit run_mon = 1'b0;
    logic [8:0] exp_q [$];

    logic [15:0] m_seq   [NV];
    logic [14:0] m_line  [NV];
    logic [31:0] m_ts    [NV];
    bit          m_first [NV];

    always #4 clk = ~clk;

    for (genvar g = 0; g < NV; g++) begin : g_cfg
        assign cfg_ssrc[32*g +: 32] = 32'h1000_0000 + 32'(g) * 32'h0101_0101;
    end

    rtp_line_packetizer #(.NUM_VC(NV), .DEPTH(DEP), .SEQ_INIT(SINIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
        .s_tready(s_tready), .s_tlast(s_tlast), .s_teof(s_teof), .s_tvc(s_tvc),
        .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready),
        .m_tlast(m_tlast), .cfg_pt(cfg_pt), .cfg_ssrc(cfg_ssrc),
        .cfg_mtu(cfg_mtu), .ts_in(ts_in), .err_drop(err_drop)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pix(input int vc, input int i, input int len);
        return 8'((vc * 37) + (i * 7) + len);
    endfunction

    function automatic string req_of(input int pos);
        if (pos < 2) return "R2/R7";
        if (pos < 4) return "R3";
        if (pos < 8) return "R4";
        if (pos < 12) return "R5";
        if (pos < 20) return "R6";
        return "R1";
    endfunction

    // Model of one line: pushes the expected packet bytes or counts a drop.
    task automatic model_line(input int vc, input int len, input bit eof);
        bit drop;
        logic [14:0] ln;
        logic [31:0] ts;
        logic [31:0] ss;
        logic [7:0]  b [20];
        drop = (len > DEP) || (len + 20 > int'(cfg_mtu));
        ln = m_first[vc] ? 15'd0 : m_line[vc];
        ts = m_first[vc] ? ts_in : m_ts[vc];
        ss = 32'h1000_0000 + 32'(vc) * 32'h0101_0101;
        if (drop) begin
            drops_exp++;
        end else begin
            b = '{8'h80, {eof, cfg_pt}, m_seq[vc][15:8], m_seq[vc][7:0],
                  ts[31:24], ts[23:16], ts[15:8], ts[7:0],
                  ss[31:24], ss[23:16], ss[15:8], ss[7:0],
                  8'h00, 8'h00, 8'(len >> 8), 8'(len), {1'b0, ln[14:8]}, ln[7:0],
                  8'h00, 8'h00};
            for (int i = 0; i < 20; i++) exp_q.push_back({1'b0, b[i]});
            for (int i = 0; i < len; i++) exp_q.push_back({i == len - 1, pix(vc, i, len)});
            m_seq[vc] = m_seq[vc] + 16'd1;
            pkts_exp++;
        end
        m_line[vc] = ln + 15'd1;
        m_ts[vc] = ts;
        m_first[vc] = eof;
    endtask

    // Drives one line byte by byte, honouring s_tready.
    task automatic send_line(input int vc, input int len, input bit eof, input logic [31:0] ts);
        @(negedge clk);
        ts_in = ts;
        model_line(vc, len, eof);
        for (int i = 0; i < len; i++) begin
            s_tvalid = 1'b1;
            s_tdata = pix(vc, i, len);
            s_tlast = (i == len - 1);
            s_teof = eof;
            s_tvc = 2'(vc);
            while (!s_tready) @(negedge clk);
            @(posedge clk);
            @(negedge clk);
        end
        s_tvalid = 1'b0;
        s_tlast = 1'b0;
    endtask

    // Random downstream readiness, changed just after each edge.
    always @(posedge clk) begin
        #1 m_tready <= ($urandom_range(0, 9) < 7);
    end

    // Output monitor: compares each accepted byte with the model.
    always @(negedge clk) begin
        if (run_mon && rst_n) begin
            if (err_drop) drops_seen++;
            if (m_tvalid) check(!(s_tvalid && s_tready), "R9 input taken while sending", 1, 0);
            if (m_tvalid && m_tready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1 unexpected byte", int'(m_tdata), 0);
                end else begin
                    logic [8:0] e;
                    e = exp_q.pop_front();
                    check(m_tdata == e[7:0], req_of(byte_pos), int'(m_tdata), int'(e[7:0]));
                    check(m_tlast == e[8], "R1 last flag", int'(m_tlast), int'(e[8]));
                end
                byte_pos = m_tlast ? 0 : byte_pos + 1;
                if (m_tlast) pkts_seen++;
            end
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int v = 0; v < NV; v++) begin
            m_seq[v] = SINIT; m_line[v] = '0; m_ts[v] = '0; m_first[v] = 1'b1;
        end
        fork
            begin
                repeat (4) @(posedge clk);
                @(negedge clk);
                check(s_tready == 1'b1, "R10 s_tready in reset", int'(s_tready), 1);
                check(m_tvalid == 1'b0, "R10 m_tvalid in reset", int'(m_tvalid), 0);
                rst_n = 1'b1;
                @(negedge clk);
                check(s_tready == 1'b1 && err_drop == 1'b0, "R10 after reset", int'(s_tready), 1);
                run_mon = 1'b1;
                // Directed: frame on channel 0 crossing the sequence wrap (R3, R4, R7).
                send_line(0, 5, 1'b0, 32'hAABB_0001);
                send_line(0, 7, 1'b0, 32'hAABB_0002);
                send_line(0, 3, 1'b0, 32'hAABB_0003);
                send_line(0, 1, 1'b1, 32'hAABB_0004);
                send_line(0, 9, 1'b0, 32'hCCDD_0005);
                // Directed: size limit at exactly the configured packet size (R8).
                cfg_mtu = 16'd100;
                send_line(1, 80, 1'b0, 32'h0000_0100);
                send_line(1, 81, 1'b0, 32'h0000_0101);
                send_line(1, 4, 1'b1, 32'h0000_0102);
                cfg_mtu = 16'd9000;
                // Directed: store depth limit (R8, R1).
                send_line(2, DEP, 1'b0, 32'h0000_0200);
                send_line(2, DEP + 1, 1'b1, 32'h0000_0201);
                send_line(2, 2, 1'b1, 32'h0000_0202);
                cfg_mtu = 16'd1500;
                // Random interleaved channels (R1-R7).
                for (int n = 0; n < 60; n++) begin
                    send_line($urandom_range(0, NV - 1), $urandom_range(1, 120),
                              ($urandom_range(0, 3) == 0), $urandom);
                end
                while (exp_q.size() != 0 || m_tvalid) @(negedge clk);
                repeat (5) @(negedge clk);
            end
            begin
                repeat (150000) @(posedge clk);
                check(1'b0, "watchdog expired", 0, 1);
            end
        join_any
        disable fork;
        check(pkts_seen == pkts_exp, "R1 packet count", pkts_seen, pkts_exp);
        check(drops_seen == drops_exp, "R8 drop pulses", drops_seen, drops_exp);
        check(exp_q.size() == 0, "R1 missing bytes", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule